// File: doc/BRIEF.md
# Voting Bit-Clock Recovery Stage

This block sits at the front of a serial receiver whose line is oversampled eight times per bit. The asynchronous line first passes through a two-flop synchronizer. A short history register and a five-input majority voter then remove short spikes and produce a filtered line value. A sample counter that runs freely from 1 to 8 issues one strobe per bit period. At each strobe the filtered value is latched as the received bit.

The counter is kept aligned to the sender in one way only. A falling edge of the filtered value is taken as a sync point when the frame decoder downstream says it is idle or in the second bit of a byte-start pair. At a sync point the counter is forced to a fixed load value. The strobe count sits three above that load value, so sampling stays near the middle of each bit even when the two clocks drift.

Top module: `vr_bitclk_recover`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its idle state. In the cycle after reset is released, `voted_o` = 1, `sync_o` = 0, `strobe_o` = 0, `bit_o` = 1 and the internal sample count is 1.
- R2: The line is synchronized by two flops and voted over five consecutive synchronized samples, and the result is registered. Suppose `line_i` holds value x at seven consecutive rising edges E0..E6, and before that it held the other value long enough for `voted_o` to settle. Then `voted_o` equals x after edges E4 through E10, and still shows the old value after E3 and again after E11.
- R3: A line pulse that lasts only two sampling edges never changes `voted_o`.
- R4: With no sync, the sample count steps 1,2,…,8 and then wraps to 1. Strobes are therefore exactly 8 cycles apart, and the first one comes 4 cycles after reset is released.
- R5: `strobe_o` is high exactly in the cycles where the sample count equals 5, except as R8 states.
- R6: `sync_o` pulses high for one cycle when `voted_o` goes from 1 to 0 while `qual_i` is high. In the following cycle the count is 2, so the next strobe comes 4 cycles after the sync cycle.
- R7: A rising edge of `voted_o`, or a falling edge while `qual_i` is low, raises no `sync_o` and leaves the strobe cadence unchanged.
- R8: In a cycle where `sync_o` is high, `strobe_o` is held low even if the count equals 5.
- R9: At each strobe, `bit_o` takes the value `voted_o` has in that cycle, and the new value appears in the next cycle. Between strobes `bit_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous serial line |
| qual_i | input | 1 | High while the frame decoder is idle or in the second byte-start bit |
| voted_o | output | 1 | Registered majority-filtered line value |
| sync_o | output | 1 | One-cycle re-phase pulse |
| strobe_o | output | 1 | Bit-centre sampling strobe |
| bit_o | output | 1 | Value latched at the last strobe |

## Verification
The first stimulus is a seven-sample low run on an idle-high line. It pins down the exact first and last cycle of the filtered output, so an extra or missing pipeline stage, or a wrong vote threshold, shows up. A two-sample spike separates a true majority from a plain delay line. The same falling edge is then applied with the qualifier high and with it low, timed so that the sync lands on a count of 5. The strobe positions after that edge (cycle 16 against cycles 12 and 20), the strobe in the coincident cycle, and the latched bit separate re-phasing from free running. A slow rising edge with the qualifier high shows that only falling edges re-phase the counter.

// File: rtl/vr_pkg.sv
package vr_pkg;

    // widest voting window supported by the popcount helper
    localparam int unsigned VR_MAX_WIN = 16;

    // pulses produced by the phase controller in one cycle
    typedef struct packed {
        logic sync;
        logic strobe;
    } vr_pulse_t;

    // strict majority over the lowest 'width' bits of 'bits'
    function automatic logic maj_of(input logic [VR_MAX_WIN-1:0] bits,
                                    input int unsigned width);
        int unsigned ones;
        ones = 0;
        for (int unsigned i = 0; i < VR_MAX_WIN; i++) begin
            if (i < width && bits[i]) ones = ones + 1;
        end
        return (2 * ones > width);
    endfunction

endpackage

// File: rtl/vr_line_sync.sv
module vr_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic samp_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= line_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
                AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (rst)
                    1'b1 |=> chain_q[g] == $past(chain_q[g-1])); // R2
            end
        end
    endgenerate

    assign samp_o = chain_q[STAGES-1];

endmodule

// File: rtl/vr_vote_filter.sv
module vr_vote_filter
    import vr_pkg::*;
#(
    parameter int unsigned HIST = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_i,
    output logic voted_o
);
    localparam int unsigned WIN = HIST + 1;

    logic [HIST-1:0]       hist_q;
    logic [WIN-1:0]        win;
    logic [VR_MAX_WIN-1:0] win_ext;
    logic                  voted_q;

    assign win     = {hist_q, samp_i};
    assign win_ext = VR_MAX_WIN'(win);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '1;
            voted_q <= 1'b1;
        end else begin
            hist_q  <= win[HIST-1:0];
            voted_q <= maj_of(win_ext, WIN);
        end
    end

    assign voted_o = voted_q;

    AST_VOTE_ONES: assert property (@(posedge clk) disable iff (rst)
        (&win) |=> voted_q); // R2
    AST_VOTE_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (win == '0) |=> !voted_q); // R3

endmodule

// File: rtl/vr_phase_ctrl.sv
module vr_phase_ctrl
    import vr_pkg::*;
#(
    parameter int unsigned CNT_MAX   = 8,
    parameter int unsigned SYNC_LOAD = 2,
    parameter int unsigned STROBE_AT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic voted_i,
    input  logic qual_i,
    output logic sync_o,
    output logic strobe_o,
    output logic bit_o
);
    localparam int unsigned CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] MAX_V    = CW'(CNT_MAX);
    localparam logic [CW-1:0] LOAD_V   = CW'(SYNC_LOAD);
    localparam logic [CW-1:0] STROBE_V = CW'(STROBE_AT);
    localparam logic [CW-1:0] FIRST_V  = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          prev_q;
    logic          bit_q;
    vr_pulse_t     pulse;

    always_comb begin
        pulse.sync   = qual_i && prev_q && !voted_i;
        pulse.strobe = (cnt_q == STROBE_V) && !pulse.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= FIRST_V;
            prev_q <= 1'b1;
            bit_q  <= 1'b1;
        end else begin
            prev_q <= voted_i;
            if (pulse.sync)          cnt_q <= LOAD_V;
            else if (cnt_q == MAX_V) cnt_q <= FIRST_V;
            else                     cnt_q <= cnt_q + FIRST_V;
            if (pulse.strobe)        bit_q <= voted_i;
        end
    end

    assign sync_o   = pulse.sync;
    assign strobe_o = pulse.strobe;
    assign bit_o    = bit_q;

    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (rst)
        pulse.sync |=> cnt_q == LOAD_V); // R6
    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse.sync |=> !pulse.sync); // R6
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!pulse.sync && cnt_q == MAX_V) |=> cnt_q == FIRST_V); // R4
    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (rst)
        pulse.strobe |=> !pulse.strobe); // R5
    AST_NO_STROBE_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
        pulse.sync |-> !pulse.strobe); // R8
    AST_BIT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        pulse.strobe |=> bit_q == $past(voted_i)); // R9
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pulse.strobe |=> $stable(bit_q)); // R9

endmodule

// File: rtl/vr_bitclk_recover.sv
module vr_bitclk_recover #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HIST        = 4,
    parameter int unsigned CNT_MAX     = 8,
    parameter int unsigned SYNC_LOAD   = 2,
    parameter int unsigned STROBE_AT   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic qual_i,
    output logic voted_o,
    output logic sync_o,
    output logic strobe_o,
    output logic bit_o
);
    logic samp;
    logic voted;

    vr_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .samp_o (samp)
    );

    vr_vote_filter #(.HIST(HIST)) i_vote (
        .clk     (clk),
        .rst     (rst),
        .samp_i  (samp),
        .voted_o (voted)
    );

    vr_phase_ctrl #(
        .CNT_MAX   (CNT_MAX),
        .SYNC_LOAD (SYNC_LOAD),
        .STROBE_AT (STROBE_AT)
    ) i_phase (
        .clk      (clk),
        .rst      (rst),
        .voted_i  (voted),
        .qual_i   (qual_i),
        .sync_o   (sync_o),
        .strobe_o (strobe_o),
        .bit_o    (bit_o)
    );

    assign voted_o = voted;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (voted_o && !sync_o && bit_o)); // R1

endmodule

// File: tb/test_vr_bitclk_recover.sv
`timescale 1ns/1ps
module test_vr_bitclk_recover;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_i = 1'b1;
    logic qual_i = 1'b0;
    logic voted_o, sync_o, strobe_o, bit_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vr_bitclk_recover i_vr_bitclk_recover (
        .clk(clk), .rst(rst), .line_i(line_i), .qual_i(qual_i),
        .voted_o(voted_o), .sync_o(sync_o), .strobe_o(strobe_o), .bit_o(bit_o)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // leaves the bench at cycle N0: first negedge after reset release
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; line_i = 1'b1; qual_i = 1'b0;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_cadence();
        do_reset();
        check(voted_o, 1'b1, "R1 voted after reset");
        check(sync_o, 1'b0, "R1 sync after reset");
        check(bit_o, 1'b1, "R1 bit after reset");
        for (int k = 0; k < 24; k++) begin
            check(strobe_o, (k % 8) == 4, $sformatf("R4 R5 strobe at cycle %0d", k));
            tick(1);
        end
    endtask

    task automatic t_window();
        do_reset();
        line_i = 1'b0;
        for (int k = 0; k < 14; k++) begin
            if (k == 7) line_i = 1'b1;
            check(voted_o, !(k >= 5 && k <= 11), $sformatf("R2 voted at cycle %0d", k));
            tick(1);
        end
    endtask

    task automatic t_spike();
        logic seen_low;
        seen_low = 1'b0;
        do_reset();
        line_i = 1'b0;
        for (int k = 0; k < 16; k++) begin
            if (k == 2) line_i = 1'b1;
            if (!voted_o) seen_low = 1'b1;
            tick(1);
        end
        check(seen_low, 1'b0, "R3 two-sample spike reached voted output");
    endtask

    // falling edge timed so the sync cycle coincides with count 5 (cycle 12)
    task automatic t_fall(input logic qv);
        string tag;
        tag = qv ? "qual high" : "qual low";
        do_reset();
        qual_i = qv;
        tick(7);
        line_i = 1'b0;
        tick(4);                                   // N11
        check(sync_o, 1'b0, {"R6 no sync before edge, ", tag});
        tick(1);                                   // N12
        if (qv) check(sync_o, 1'b1, "R6 sync on qualified fall");
        else    check(sync_o, 1'b0, "R7 no sync with qual low");
        check(strobe_o, !qv, {"R8 strobe in sync cycle, ", tag});
        tick(1);                                   // N13
        check(sync_o, 1'b0, {"R6 sync lasts one cycle, ", tag});
        check(bit_o, qv, {"R9 bit after cycle 12, ", tag});
        tick(3);                                   // N16
        check(strobe_o, qv, {"R6 strobe 4 after sync, ", tag});
        tick(1);                                   // N17
        check(bit_o, 1'b0, {"R9 bit after cycle 16, ", tag});
        tick(3);                                   // N20
        check(strobe_o, !qv, {"R7 old-phase strobe, ", tag});
        tick(4);                                   // N24
        check(strobe_o, qv, {"R6 new-phase period, ", tag});
    endtask

    task automatic t_rise();
        logic seen_sync;
        seen_sync = 1'b0;
        do_reset();
        line_i = 1'b0;
        tick(16);                                  // N16, voted low
        check(voted_o, 1'b0, "R2 voted low before rise");
        qual_i = 1'b1;
        line_i = 1'b1;
        for (int k = 16; k < 32; k++) begin
            if (sync_o) seen_sync = 1'b1;
            if (k == 20 || k == 28) check(strobe_o, 1'b1, $sformatf("R7 cadence at %0d", k));
            tick(1);
        end
        check(seen_sync, 1'b0, "R7 sync on rising edge");
        check(voted_o, 1'b1, "R2 voted high after rise");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_cadence();
        t_window();
        t_spike();
        t_fall(1'b1);
        t_fall(1'b0);
        t_rise();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule